// File: doc/BRIEF.md
# Preemptible Eight-Channel Block-Copy DMA Engine

This engine copies bytes from a per-channel source address to one fixed destination port. Software loads a source address and a byte count for each channel. It then writes a start mask, and every channel whose bit is set is run to completion in turn, starting from the lowest index. Each byte is moved as a read from memory followed by a write to the port. The engine keeps a running master-cycle cost for the whole launch and reports it when the launch ends.

A separate per-line DMA mechanism can take channels away from the engine. A frame-init pulse or a line-service pulse marks each channel in its enable mask as cancelled. A cancelled channel is passed over when its turn comes. A running channel stops after the byte in flight and keeps its remaining count and address, so a later start can resume it. Any accepted start write clears every cancellation flag.

The sequencer has five states. IDLE waits for a start write (IDLE->SCAN). SCAN looks at one channel per cycle: it moves to RD when the channel is enabled, not cancelled and has bytes left; to FIN after the last channel; otherwise it stays in SCAN on the next index. RD holds a read until ready (RD->WR). WR holds the port write until ready, then goes back to RD for the next byte. When the channel is finished or cancelled, WR goes to SCAN, or to FIN after the last channel. FIN signals done (FIN->IDLE).

Top module: `pdma_engine`

## Requirements
- R1: Bit i of the start mask (register select 2, data bits 7:0) enables channel i, and enabled channels are serviced in ascending index order, each one finishing before the next begins.
- R2: Each byte is a read at the channel source address (write enable low), then a write of that byte to the fixed port address DEST (default 16'h00F0). Per byte, the source address rises by one and the count falls by one, and the channel ends when the count reaches zero. A channel whose count is zero at its turn moves nothing.
- R3: After a launch, cycle_count equals 8 + 8 per enabled channel (skipped channels included) + 8 per byte moved.
- R4: An accepted start write clears the cancellation flag of all eight channels before any channel is examined.
- R5: A channel whose flag is set when its turn comes moves no byte, and its count and address are unchanged.
- R6: The flag is checked after every byte. Once it is set, the running channel stops after the byte already issued, and its remaining count and next address are kept. A flag set while a byte waits on the bus takes effect before the next byte is issued.
- R7: A frame-init pulse sets the flag of every channel in init_mask and copies each such channel's source address into its table-address register.
- R8: A line-service pulse sets the flag of every channel in svc_mask.
- R9: busy is high from the cycle after an accepted start write until the last channel ends. Then done is high for exactly one cycle while busy is low.
- R10: Register writes of every kind (select 0 source, 1 count, 2 start) are ignored while busy is high.
- R11: Once mem_req is raised, it stays high with a stable address and direction until mem_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 source address, 1 byte count, 2 start mask |
| reg_chan | input | 3 | Channel index for select 0 and 1 |
| reg_wdata | input | 16 | Write data |
| line_init | input | 1 | Per-line DMA frame-init pulse |
| init_mask | input | 8 | Channels selected by line_init |
| line_svc | input | 1 | Per-line DMA line-service pulse |
| svc_mask | input | 8 | Channels serviced by line_svc |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 16 | Bus address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with mem_ready |
| mem_ready | input | 1 | Completes the current request |
| busy | output | 1 | Launch in progress |
| done | output | 1 | One-cycle end-of-launch pulse |
| cycle_count | output | 24 | Master-cycle cost of the latest launch |
| stat_chan | input | 3 | Channel selected for readback |
| stat_src | output | 16 | Current source address of stat_chan |
| stat_count | output | 16 | Remaining count of stat_chan |
| stat_table | output | 16 | Table-address register of stat_chan |
| stat_cancel | output | 1 | Cancellation flag of stat_chan |

## Verification
The assertions assume that the bus keeps mem_ready low while no request is raised and answers every request in finite time. The bench memory model only raises ready after a one-cycle wait on a live request. The flag properties assume that a start write is only accepted while idle. The stimulus therefore issues preemption pulses either during a transfer or alone in a cycle, and never in the same cycle as an accepted start write. Register writes made while busy are deliberate tests of R10, not normal traffic.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_SCAN,
        S_RD,
        S_WR,
        S_FIN
    } pdma_state_t;

    localparam logic [1:0] SEL_SRC   = 2'd0;
    localparam logic [1:0] SEL_CNT   = 2'd1;
    localparam logic [1:0] SEL_START = 2'd2;
    localparam int unsigned CYC_STEP = 8;
endpackage

// File: rtl/pdma_chan_regs.sv
module pdma_chan_regs #(
    parameter int NCH = 8,
    parameter int AW  = 16,
    parameter int CW  = 16,
    localparam int PW = $clog2(NCH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCH-1:0]          src_we,
    input  logic [NCH-1:0]          cnt_we,
    input  logic [AW-1:0]           wdata,
    input  logic                    clr_all,
    input  logic                    init_pulse,
    input  logic [NCH-1:0]          init_sel,
    input  logic                    svc_pulse,
    input  logic [NCH-1:0]          svc_sel,
    input  logic                    step_en,
    input  logic [PW-1:0]           step_ch,
    output logic [NCH-1:0][AW-1:0]  src_q,
    output logic [NCH-1:0][CW-1:0]  cnt_q,
    output logic [NCH-1:0][AW-1:0]  tbl_q,
    output logic [NCH-1:0]          cancel_q,
    output logic [NCH-1:0]          cancel_nxt
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic set_g;
        logic step_g;
        assign set_g  = (init_pulse && init_sel[g]) || (svc_pulse && svc_sel[g]);
        assign step_g = step_en && (step_ch == PW'(g));
        // a preemption in the same cycle as a clear wins
        assign cancel_nxt[g] = set_g || (cancel_q[g] && !clr_all);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                src_q[g]    <= '0;
                cnt_q[g]    <= '0;
                tbl_q[g]    <= '0;
                cancel_q[g] <= 1'b0;
            end else begin
                cancel_q[g] <= cancel_nxt[g];
                if (src_we[g])       src_q[g] <= wdata;
                else if (step_g)     src_q[g] <= src_q[g] + AW'(1);
                if (cnt_we[g])       cnt_q[g] <= CW'(wdata);
                else if (step_g)     cnt_q[g] <= cnt_q[g] - CW'(1);
                if (init_pulse && init_sel[g]) tbl_q[g] <= src_q[g];
            end
        end
    end
endmodule

// File: rtl/pdma_seq.sv
module pdma_seq
    import pdma_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int AW   = 16,
    parameter int CW   = 16,
    parameter int CYCW = 24,
    parameter logic [AW-1:0] DEST = 16'h00F0,
    localparam int PW  = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [NCH-1:0]  start_mask,
    input  logic [AW-1:0]   cur_src,
    input  logic [CW-1:0]   cur_cnt,
    input  logic            cur_cancel,
    input  logic            cur_cancel_nxt,
    output logic [PW-1:0]   ch_ptr,
    output logic            step_en,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [7:0]      mem_wdata,
    input  logic [7:0]      mem_rdata,
    input  logic            mem_ready,
    output logic            busy,
    output logic            done,
    output logic [CYCW-1:0] cycle_count
);
    pdma_state_t state, state_nxt;
    logic [NCH-1:0]  mask_q;
    logic [7:0]      data_q;
    logic [CYCW-1:0] cyc_q;
    logic            last_ch, ch_en, ch_go, wr_end;

    assign last_ch = (ch_ptr == PW'(NCH - 1));
    assign ch_en   = mask_q[ch_ptr];
    assign ch_go   = ch_en && !cur_cancel_nxt && (cur_cnt != '0);
    assign wr_end  = (cur_cnt == CW'(1)) || cur_cancel_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE: if (start) state_nxt = S_SCAN;
            S_SCAN: begin
                if (ch_go)        state_nxt = S_RD;
                else if (last_ch) state_nxt = S_FIN;
            end
            S_RD:   if (mem_ready) state_nxt = S_WR;
            S_WR: begin
                if (mem_ready) begin
                    if (!wr_end)      state_nxt = S_RD;
                    else if (last_ch) state_nxt = S_FIN;
                    else              state_nxt = S_SCAN;
                end
            end
            S_FIN:  state_nxt = S_IDLE;
            default: state_nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_ptr <= '0;
            mask_q <= '0;
            data_q <= '0;
            cyc_q  <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    ch_ptr <= '0;
                    mask_q <= start_mask;
                    cyc_q  <= CYCW'(CYC_STEP);
                end
                S_SCAN: begin
                    if (ch_en) cyc_q <= cyc_q + CYCW'(CYC_STEP);
                    if (!ch_go && !last_ch) ch_ptr <= ch_ptr + PW'(1);
                end
                S_RD: if (mem_ready) data_q <= mem_rdata;
                S_WR: if (mem_ready) begin
                    cyc_q <= cyc_q + CYCW'(CYC_STEP);
                    if (wr_end && !last_ch) ch_ptr <= ch_ptr + PW'(1);
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        mem_req     = (state == S_RD) || (state == S_WR);
        mem_we      = (state == S_WR);
        mem_addr    = (state == S_WR) ? DEST : cur_src;
        mem_wdata   = data_q;
        step_en     = (state == S_WR) && mem_ready;
        busy        = (state == S_SCAN) || mem_req;
        done        = (state == S_FIN);
        cycle_count = cyc_q;
    end
endmodule

// File: rtl/pdma_engine.sv
module pdma_engine
    import pdma_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int AW   = 16,
    parameter int CW   = 16,
    parameter int CYCW = 24,
    parameter logic [AW-1:0] DEST = 16'h00F0,
    localparam int PW  = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [1:0]      reg_sel,
    input  logic [PW-1:0]   reg_chan,
    input  logic [AW-1:0]   reg_wdata,
    input  logic            line_init,
    input  logic [NCH-1:0]  init_mask,
    input  logic            line_svc,
    input  logic [NCH-1:0]  svc_mask,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [7:0]      mem_wdata,
    input  logic [7:0]      mem_rdata,
    input  logic            mem_ready,
    output logic            busy,
    output logic            done,
    output logic [CYCW-1:0] cycle_count,
    input  logic [PW-1:0]   stat_chan,
    output logic [AW-1:0]   stat_src,
    output logic [CW-1:0]   stat_count,
    output logic [AW-1:0]   stat_table,
    output logic            stat_cancel
);
    logic                   wr_ok, start_acc, step_en;
    logic [NCH-1:0]         src_we, cnt_we, cancel_q, cancel_nxt;
    logic [NCH-1:0][AW-1:0] src_q, tbl_q;
    logic [NCH-1:0][CW-1:0] cnt_q;
    logic [PW-1:0]          ch_ptr;

    assign wr_ok     = reg_we && !busy;
    assign start_acc = wr_ok && (reg_sel == SEL_START);

    for (genvar g = 0; g < NCH; g++) begin : g_dec
        assign src_we[g] = wr_ok && (reg_sel == SEL_SRC) && (reg_chan == PW'(g));
        assign cnt_we[g] = wr_ok && (reg_sel == SEL_CNT) && (reg_chan == PW'(g));
    end

    pdma_chan_regs #(.NCH(NCH), .AW(AW), .CW(CW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_we     (src_we),
        .cnt_we     (cnt_we),
        .wdata      (reg_wdata),
        .clr_all    (start_acc),
        .init_pulse (line_init),
        .init_sel   (init_mask),
        .svc_pulse  (line_svc),
        .svc_sel    (svc_mask),
        .step_en    (step_en),
        .step_ch    (ch_ptr),
        .src_q      (src_q),
        .cnt_q      (cnt_q),
        .tbl_q      (tbl_q),
        .cancel_q   (cancel_q),
        .cancel_nxt (cancel_nxt)
    );

    pdma_seq #(.NCH(NCH), .AW(AW), .CW(CW), .CYCW(CYCW), .DEST(DEST)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start_acc),
        .start_mask     (reg_wdata[NCH-1:0]),
        .cur_src        (src_q[ch_ptr]),
        .cur_cnt        (cnt_q[ch_ptr]),
        .cur_cancel     (cancel_q[ch_ptr]),
        .cur_cancel_nxt (cancel_nxt[ch_ptr]),
        .ch_ptr         (ch_ptr),
        .step_en        (step_en),
        .mem_req        (mem_req),
        .mem_we         (mem_we),
        .mem_addr       (mem_addr),
        .mem_wdata      (mem_wdata),
        .mem_rdata      (mem_rdata),
        .mem_ready      (mem_ready),
        .busy           (busy),
        .done           (done),
        .cycle_count    (cycle_count)
    );

    assign stat_src    = src_q[stat_chan];
    assign stat_count  = cnt_q[stat_chan];
    assign stat_table  = tbl_q[stat_chan];
    assign stat_cancel = cancel_q[stat_chan];
endmodule

// File: rtl/pdma_checker.sv
module pdma_checker #(
    parameter int NCH = 8,
    parameter int AW  = 16,
    parameter logic [AW-1:0] DEST = 16'h00F0
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           done,
    input logic           mem_req,
    input logic           mem_we,
    input logic [AW-1:0]  mem_addr,
    input logic           mem_ready,
    input logic           start_acc,
    input logic           line_init,
    input logic [NCH-1:0] init_mask,
    input logic           line_svc,
    input logic [NCH-1:0] svc_mask,
    input logic [NCH-1:0] cancel_q
);
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    p_dest_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_addr == DEST);

    p_clear_on_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc && !line_init && !line_svc |=> cancel_q == '0);

    p_init_marks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        line_init |=> (cancel_q & $past(init_mask)) == $past(init_mask));

    p_svc_marks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        line_svc |=> (cancel_q & $past(svc_mask)) == $past(svc_mask));

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind pdma_engine pdma_checker #(.NCH(NCH), .AW(AW), .DEST(DEST)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_ready (mem_ready),
    .start_acc (start_acc),
    .line_init (line_init),
    .init_mask (init_mask),
    .line_svc  (line_svc),
    .svc_mask  (svc_mask),
    .cancel_q  (cancel_q)
);

// File: tb/pdma_engine_tb.sv
module pdma_engine_tb;
    localparam logic [15:0] DEST = 16'h00F0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [2:0]  reg_chan = '0;
    logic [15:0] reg_wdata = '0;
    logic        line_init = 1'b0, line_svc = 1'b0;
    logic [7:0]  init_mask = '0, svc_mask = '0;
    logic        mem_req, mem_we, mem_ready;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        busy, done;
    logic [23:0] cycle_count;
    logic [2:0]  stat_chan = '0;
    logic [15:0] stat_src, stat_count, stat_table;
    logic        stat_cancel;

    always #2 clk = ~clk;

    pdma_engine u_dut (.*);

    // memory model: one wait cycle per request
    logic [1:0] wait_cnt = '0;
    int         wr_cnt = 0;
    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h3C;
    endfunction
    assign mem_ready = mem_req && (wait_cnt == 2'd1);
    assign mem_rdata = mem_byte(mem_addr);
    always @(posedge clk) begin
        if (!mem_req || mem_ready) wait_cnt <= '0;
        else                       wait_cnt <= wait_cnt + 2'd1;
        if (mem_req && mem_we && mem_ready) wr_cnt <= wr_cnt + 1;
    end

    int    n_vec = 0, n_bad = 0;
    bit    finished = 0;
    string cur_tag = "R2";
    logic [7:0] exp_q[$];

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver side of scoreboard
    task automatic expect_run(input logic [15:0] src, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(mem_byte(src + 16'(i)));
    endtask

    // monitor side of scoreboard
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_we && mem_ready) begin
            check(mem_addr == DEST, "R2 dest", mem_addr, DEST);
            if (exp_q.size() == 0) check(1'b0, {cur_tag, " unexpected write"}, mem_wdata, 0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(mem_wdata == e, {cur_tag, " data"}, mem_wdata, e);
            end
        end
    end

    task automatic reg_write(input logic [1:0] sel, input int ch, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_chan = 3'(ch); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic setup_ch(input int ch, input logic [15:0] src, input logic [15:0] cnt);
        reg_write(2'd0, ch, src);
        reg_write(2'd1, ch, cnt);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
        check(done && !busy, "R9 done pulse with busy low", {done, busy}, 2'b10);
        @(negedge clk);
        check(!done, "R9 done single cycle", done, 0);
    endtask

    task automatic wait_writes(input int n);
        for (int i = 0; i < 2000 && wr_cnt < n; i++) @(negedge clk);
    endtask

    task automatic pulse(input bit is_init, input logic [7:0] m);
        if (is_init) begin line_init = 1'b1; init_mask = m; end
        else         begin line_svc  = 1'b1; svc_mask  = m; end
        @(negedge clk);
        line_init = 1'b0; line_svc = 1'b0;
    endtask

    task automatic stat(input int ch);
        stat_chan = 3'(ch);
        #0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check(!busy && !done && !mem_req, "reset outputs", {busy, done, mem_req}, 0);
        stat(0);
        check(stat_count == 0 && !stat_cancel, "reset regs", stat_count, 0);

        // A: two channels, full transfers, ascending order (R1, R2, R3)
        cur_tag = "R1";
        setup_ch(2, 16'h0200, 16'd3);
        setup_ch(0, 16'h0100, 16'd4);
        expect_run(16'h0100, 4);
        expect_run(16'h0200, 3);
        reg_write(2'd2, 0, 16'h0005);
        check(busy, "R9 busy after start", busy, 1);
        wait_done();
        check(exp_q.size() == 0, "R1 all bytes in order", exp_q.size(), 0);
        check(cycle_count == 24'd80, "R3 cycles A", cycle_count, 80);
        stat(0);
        check(stat_count == 0 && stat_src == 16'h0104, "R2 ch0 end state", {stat_count, stat_src}, 32'h0000_0104);

        // B: cancel midway by line service while a byte waits (R6, R8)
        cur_tag = "R6";
        setup_ch(1, 16'h0300, 16'd10);
        expect_run(16'h0300, 4);
        reg_write(2'd2, 0, 16'h0002);
        wait_writes(wr_cnt + 3);
        pulse(1'b0, 8'h02);
        stat(1);
        check(stat_cancel, "R8 line service sets flag", stat_cancel, 1);
        wait_done();
        check(exp_q.size() == 0, "R6 stopped after in-flight byte", exp_q.size(), 0);
        stat(1);
        check(stat_count == 16'd6, "R6 remaining count", stat_count, 6);
        check(stat_src == 16'h0304, "R6 kept address", stat_src, 16'h0304);
        check(cycle_count == 24'd48, "R3 cycles B", cycle_count, 48);

        // C: frame init cancels ch4 before its turn (R5, R7)
        cur_tag = "R5";
        setup_ch(3, 16'h0400, 16'd5);
        setup_ch(4, 16'h0500, 16'd2);
        expect_run(16'h0400, 5);
        reg_write(2'd2, 0, 16'h0018);
        wait_writes(wr_cnt + 1);
        pulse(1'b1, 8'h10);
        wait_done();
        check(exp_q.size() == 0, "R5 ch4 moved nothing", exp_q.size(), 0);
        stat(4);
        check(stat_count == 16'd2 && stat_src == 16'h0500, "R5 ch4 unchanged", {stat_count, stat_src}, 32'h0002_0500);
        check(stat_table == 16'h0500, "R7 table copy", stat_table, 16'h0500);
        check(cycle_count == 24'd64, "R3 cycles C skipped channel counted", cycle_count, 64);

        // D: new start clears flags and resumes ch1 (R4)
        cur_tag = "R4";
        expect_run(16'h0304, 6);
        reg_write(2'd2, 0, 16'h0002);
        stat(1);
        check(!stat_cancel, "R4 flag cleared by start", stat_cancel, 0);
        stat(4);
        check(!stat_cancel, "R4 all flags cleared", stat_cancel, 0);
        wait_done();
        check(exp_q.size() == 0, "R4 resumed bytes", exp_q.size(), 0);
        stat(1);
        check(stat_count == 0, "R4 ch1 finished", stat_count, 0);
        check(cycle_count == 24'd64, "R3 cycles D", cycle_count, 64);

        // E: zero count moves nothing (R2)
        cur_tag = "R2";
        setup_ch(5, 16'h0700, 16'd0);
        reg_write(2'd2, 0, 16'h0020);
        wait_done();
        check(cycle_count == 24'd16, "R2 zero count cycles", cycle_count, 16);

        // F: writes while busy ignored (R10)
        cur_tag = "R10";
        setup_ch(6, 16'h0600, 16'd3);
        expect_run(16'h0600, 3);
        reg_write(2'd2, 0, 16'h0040);
        reg_write(2'd1, 6, 16'd20);
        reg_write(2'd0, 6, 16'h0F00);
        reg_write(2'd2, 0, 16'h0040);
        wait_done();
        repeat (5) @(negedge clk);
        check(!busy, "R10 no restart", busy, 0);
        check(exp_q.size() == 0, "R10 exactly three bytes", exp_q.size(), 0);
        stat(6);
        check(stat_count == 0 && stat_src == 16'h0603, "R10 regs untouched", {stat_count, stat_src}, 32'h0000_0603);
        check(cycle_count == 24'd40, "R3 cycles F", cycle_count, 40);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule